// File: doc/BRIEF.md
# Hardware Address Breakpoint Unit

This block sits beside a processor core and compares each bus access the core makes against four programmable breakpoint addresses. The addresses it compares are linear addresses, produced after segmentation and before any page translation. A match therefore does not depend on where the access lands in physical memory. Because the comparison is done in hardware, breakpoints work on code held in read-only memory, and no instruction has to be patched.

Each comparator channel has its own address register, an enable bit and a two-bit mode. The mode selects which accesses the channel reacts to: instruction fetches only, data writes only, or any data read or write. When an enabled channel matches a valid access, the unit raises a break request for one clock. It also sets that channel's bit in a sticky status register, so the exception handler can find out which channel or channels fired.

Software reaches the six registers through a simple indexed write port and a combinational read port. The registers are four address registers, one shared control register and one status register. Address translation, the exception handler and the pipeline are outside this block.

Top module: `addr_brk_unit`

## Requirements
- R1: After reset, all six registers read 0, `brk_status` is 0 and `brk_req` is 0.
- R2: Register index 0..3 selects the address register of channel 0..3, index 4 the control register, index 5 the status register. Index 6 and 7 read 0. A register written with `cfg_we` reads back its value from the next cycle on. The control register holds channel i's enable in bit i and its mode in bits [5+2i:4+2i]. Bits above 11 read 0.
- R3: Mode 00 matches only accesses of kind 00 (instruction fetch) at the channel's address.
- R4: Mode 01 matches only accesses of kind 10 (data write) at the channel's address.
- R5: Mode 11 matches accesses of kind 01 (data read) or kind 10 (data write), and never kind 00 (fetch).
- R6: Mode 10 is reserved and never matches any access kind. An access of kind 11 never matches in any mode.
- R7: A channel whose enable bit is 0 never matches, and its status bit is left unchanged.
- R8: `brk_req` is 1 in exactly the cycle after a cycle in which `mon_valid` is 1 and at least one enabled channel matches. It is 0 otherwise, including when `mon_valid` is 0.
- R9: When several channels match the same access, all of their status bits are set in the same cycle.
- R10: Status bits are sticky. Only a write to index 5 clears them, and each bit written 0 is cleared while each bit written 1 is kept. If a match and a clearing write fall in the same cycle, the match wins.
- R11: The address comparison covers the full `AW`-bit address. A difference in any single bit, lowest or highest, gives no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index for read and write |
| cfg_wdata | input | AW (32) | Register write data |
| cfg_rdata | output | AW (32) | Combinational read data of register `cfg_idx` |
| mon_valid | input | 1 | Access on the monitor inputs is valid this cycle |
| mon_kind | input | 2 | Access kind: 00 fetch, 01 data read, 10 data write, 11 none |
| mon_addr | input | AW (32) | Linear address of the access |
| brk_req | output | 1 | Break request, one cycle after a matching access |
| brk_status | output | 4 | Sticky per-channel hit bits |

## Verification
Matches are registered, so `brk_req` and `brk_status` change at the rising edge that ends the access cycle. The bench drives an access at a falling edge and samples both outputs at the next falling edge. It then checks one falling edge later that the request has dropped. Register writes take effect at the edge that ends the write cycle. Reads are combinational, so the bench sets the index at a falling edge and samples a nanosecond later. Accesses that are expected not to match are checked in the same slot, where the request must stay 0 and the status must keep its earlier value.

// File: rtl/brk_pkg.sv
// Package: shared encodings for the address breakpoint unit.
// Assumes: access kinds and channel modes are two-bit codes as listed.
package brk_pkg;

    // Kind of bus access presented on the monitor inputs
    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;

    // Per-channel match mode held in the control register
    typedef enum logic [1:0] {
        MODE_FETCH = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_RSVD  = 2'b10,
        MODE_RDWR  = 2'b11
    } brk_mode_e;

    // Control register field helpers
    function automatic int unsigned mode_lsb(int unsigned num_ch, int unsigned ch);
        return num_ch + 2 * ch;
    endfunction

endpackage

// File: rtl/brk_regfile.sv
// Module: brk_regfile
// Holds the per-channel address registers and the shared control register,
// decodes writes to the status register into a strobe, and serves reads.
// Assumes: AW is at least 3*NUM_CH so the control register fits a word.
module brk_regfile #(
    parameter int NUM_CH = 4,
    parameter int AW     = 32,
    parameter int IDXW   = 3,
    parameter int CTLW   = 3 * NUM_CH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [IDXW-1:0]            cfg_idx,
    input  logic [AW-1:0]              cfg_wdata,
    input  logic [NUM_CH-1:0]          status_q,
    output logic [NUM_CH-1:0][AW-1:0]  addr_q,
    output logic [CTLW-1:0]            ctrl_q,
    output logic                       sts_wr,
    output logic [NUM_CH-1:0]          sts_wdata,
    output logic [AW-1:0]              cfg_rdata
);

    localparam logic [IDXW-1:0] CTL_IDX = IDXW'(NUM_CH);
    localparam logic [IDXW-1:0] STS_IDX = IDXW'(NUM_CH + 1);

    // One address register per channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_addr
        // Load channel address on a write to its index
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
            end else if (cfg_we && (cfg_idx == IDXW'(g))) begin
                addr_q[g] <= cfg_wdata;
            end
        end
    end

    // Load the shared control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_we && (cfg_idx == CTL_IDX)) begin
            ctrl_q <= cfg_wdata[CTLW-1:0];
        end
    end

    // Forward status writes to the status block
    always_comb begin
        sts_wr    = cfg_we && (cfg_idx == STS_IDX);
        sts_wdata = cfg_wdata[NUM_CH-1:0];
    end

    // Combinational read mux, unused indices return zero
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cfg_idx == IDXW'(i)) begin
                cfg_rdata = addr_q[i];
            end
        end
        if (cfg_idx == CTL_IDX) begin
            cfg_rdata = AW'(ctrl_q);
        end
        if (cfg_idx == STS_IDX) begin
            cfg_rdata = AW'(status_q);
        end
    end

endmodule

// File: rtl/brk_channel.sv
// Module: brk_channel
// One comparator channel: compares the monitored address with the channel
// address and qualifies the result by enable, mode and access kind.
// Assumes: purely combinational; the caller registers the result.
module brk_channel
    import brk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          en,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] bp_addr,
    input  logic          mon_valid,
    input  logic [1:0]    mon_kind,
    input  logic [AW-1:0] mon_addr,
    output logic          hit
);

    logic addr_eq;
    logic kind_ok;

    // Full-width address comparison
    always_comb addr_eq = (bp_addr == mon_addr);

    // Decide whether the access kind is of interest in this mode
    always_comb begin
        kind_ok = 1'b0;
        unique case (brk_mode_e'(mode))
            MODE_FETCH: kind_ok = (acc_kind_e'(mon_kind) == ACC_FETCH);
            MODE_WRITE: kind_ok = (acc_kind_e'(mon_kind) == ACC_WRITE);
            MODE_RDWR:  kind_ok = (acc_kind_e'(mon_kind) == ACC_READ) ||
                                  (acc_kind_e'(mon_kind) == ACC_WRITE);
            MODE_RSVD:  kind_ok = 1'b0;
            default:    kind_ok = 1'b0;
        endcase
    end

    // Combine all qualifiers into the channel hit
    always_comb hit = en && mon_valid && kind_ok && addr_eq;

endmodule

// File: rtl/brk_status.sv
// Module: brk_status
// Sticky hit register and one-cycle break request.
// Assumes: a match in the same cycle as a clearing write takes priority.
module brk_status #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_vec,
    input  logic              sts_wr,
    input  logic [NUM_CH-1:0] sts_wdata,
    output logic [NUM_CH-1:0] status_q,
    output logic              req_q
);

    logic [NUM_CH-1:0] kept;

    // Bits written 0 are cleared, bits written 1 are kept
    always_comb kept = sts_wr ? (status_q & sts_wdata) : status_q;

    // Update sticky status, new hits always set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= kept | hit_vec;
        end
    end

    // Register the break request for exactly one cycle per hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= |hit_vec;
        end
    end

endmodule

// File: rtl/addr_brk_unit.sv
// Module: addr_brk_unit
// Four-channel linear-address breakpoint unit with a register port.
// Assumes: mon_addr is the pre-translation linear address; AW >= 3*NUM_CH.
module addr_brk_unit
    import brk_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 32,
    parameter int IDXW   = $clog2(NUM_CH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDXW-1:0]   cfg_idx,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    input  logic              mon_valid,
    input  logic [1:0]        mon_kind,
    input  logic [AW-1:0]     mon_addr,
    output logic              brk_req,
    output logic [NUM_CH-1:0] brk_status
);

    localparam int CTLW = 3 * NUM_CH;

    logic [NUM_CH-1:0][AW-1:0] addr_q;
    logic [CTLW-1:0]           ctrl_q;
    logic                      sts_wr;
    logic [NUM_CH-1:0]         sts_wdata;
    logic [NUM_CH-1:0]         hit_vec;
    logic [NUM_CH-1:0]         status_q;
    logic                      req_q;

    brk_regfile #(
        .NUM_CH (NUM_CH),
        .AW     (AW),
        .IDXW   (IDXW),
        .CTLW   (CTLW)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .status_q  (status_q),
        .addr_q    (addr_q),
        .ctrl_q    (ctrl_q),
        .sts_wr    (sts_wr),
        .sts_wdata (sts_wdata),
        .cfg_rdata (cfg_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        brk_channel #(
            .AW (AW)
        ) ch_i (
            .en        (ctrl_q[g]),
            .mode      (ctrl_q[mode_lsb(NUM_CH, g) +: 2]),
            .bp_addr   (addr_q[g]),
            .mon_valid (mon_valid),
            .mon_kind  (mon_kind),
            .mon_addr  (mon_addr),
            .hit       (hit_vec[g])
        );
    end

    brk_status #(
        .NUM_CH (NUM_CH)
    ) sts_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_vec   (hit_vec),
        .sts_wr    (sts_wr),
        .sts_wdata (sts_wdata),
        .status_q  (status_q),
        .req_q     (req_q)
    );

    // Drive the outputs from the registered state
    always_comb begin
        brk_req    = req_q;
        brk_status = status_q;
    end

endmodule

// File: rtl/brk_checker.sv
// Module: brk_checker
// Temporal checks on the breakpoint unit, attached by bind.
// Assumes: synchronous active-low reset; all checks disabled during reset.
module brk_checker #(
    parameter int NUM_CH = 4,
    parameter int IDXW   = 3,
    parameter int CTLW   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mon_valid,
    input logic              cfg_we,
    input logic [IDXW-1:0]   cfg_idx,
    input logic [CTLW-1:0]   ctrl_q,
    input logic              brk_req,
    input logic [NUM_CH-1:0] brk_status
);

    localparam logic [IDXW-1:0] STS_IDX = IDXW'(NUM_CH + 1);

    // R8: a request only follows a valid access
    a_r8_req_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(mon_valid));

    // R8: a request always comes with at least one status bit
    a_r8_req_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (brk_status != '0));

    // R10: without a status write, no status bit falls
    a_r10_sticky_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(cfg_we) && ($past(cfg_idx) == STS_IDX))
        |-> ((brk_status & $past(brk_status)) == $past(brk_status)));

    // R9: newly set status bits appear only together with a request
    a_r9_new_bits_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((brk_status & ~$past(brk_status)) != '0) |-> brk_req);

    // R7: with every channel disabled, no request follows
    a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_q[NUM_CH-1:0]) == '0) |-> !brk_req);

endmodule

bind addr_brk_unit brk_checker #(
    .NUM_CH (NUM_CH),
    .IDXW   (IDXW),
    .CTLW   (3 * NUM_CH)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mon_valid  (mon_valid),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .ctrl_q     (ctrl_q),
    .brk_req    (brk_req),
    .brk_status (brk_status)
);

// File: tb/addr_brk_unit_tb_top.sv
`timescale 1ns/1ps
// Directed bench for addr_brk_unit: one task per scenario.
module addr_brk_unit_tb_top;

    localparam int NUM_CH = 4;
    localparam int AW     = 32;
    localparam int IDXW   = 3;

    localparam logic [1:0] K_FETCH = 2'b00;
    localparam logic [1:0] K_READ  = 2'b01;
    localparam logic [1:0] K_WRITE = 2'b10;
    localparam logic [1:0] K_NONE  = 2'b11;

    localparam logic [1:0] M_FETCH = 2'b00;
    localparam logic [1:0] M_WRITE = 2'b01;
    localparam logic [1:0] M_RSVD  = 2'b10;
    localparam logic [1:0] M_RDWR  = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [IDXW-1:0]   cfg_idx = '0;
    logic [AW-1:0]     cfg_wdata = '0;
    logic [AW-1:0]     cfg_rdata;
    logic              mon_valid = 1'b0;
    logic [1:0]        mon_kind = K_NONE;
    logic [AW-1:0]     mon_addr = '0;
    logic              brk_req;
    logic [NUM_CH-1:0] brk_status;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    addr_brk_unit #(.NUM_CH(NUM_CH), .AW(AW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .mon_valid  (mon_valid),
        .mon_kind   (mon_kind),
        .mon_addr   (mon_addr),
        .brk_req    (brk_req),
        .brk_status (brk_status)
    );

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ctl(input logic [3:0] en, input logic [1:0] m3,
                                          input logic [1:0] m2, input logic [1:0] m1,
                                          input logic [1:0] m0);
        return AW'({m3, m2, m1, m0, en});
    endfunction

    task automatic reg_write(input logic [IDXW-1:0] idx, input logic [AW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [IDXW-1:0] idx, output logic [AW-1:0] data);
        @(negedge clk);
        cfg_idx = idx;
        #1 data = cfg_rdata;
    endtask

    // One access; checks request and status at the next falling edge
    task automatic access(input string tag, input logic [1:0] kind, input logic [AW-1:0] addr,
                          input logic exp_req, input logic [3:0] exp_sts);
        @(negedge clk);
        mon_valid = 1'b1; mon_kind = kind; mon_addr = addr;
        @(negedge clk);
        mon_valid = 1'b0; mon_kind = K_NONE;
        check({tag, " req"}, AW'(brk_req), AW'(exp_req));
        check({tag, " status"}, AW'(brk_status), AW'(exp_sts));
        if (exp_req) begin
            @(negedge clk);
            check({tag, " R8 req drops"}, AW'(brk_req), '0);
        end
    endtask

    task automatic clear_status();
        reg_write(3'd5, '0);
    endtask

    task automatic t_reset();
        logic [AW-1:0] d;
        check("R1 req at reset", AW'(brk_req), '0);
        check("R1 status at reset", AW'(brk_status), '0);
        for (int i = 0; i < 8; i++) begin
            reg_read(IDXW'(i), d);
            check($sformatf("R1 R2 reg %0d after reset", i), d, '0);
        end
    endtask

    task automatic t_regmap();
        logic [AW-1:0] d;
        for (int i = 0; i < 4; i++) reg_write(IDXW'(i), 32'hA5A5_0000 + AW'(i * 16));
        reg_write(3'd4, 32'hFFFF_FFFF);
        for (int i = 0; i < 4; i++) begin
            reg_read(IDXW'(i), d);
            check($sformatf("R2 addr reg %0d", i), d, 32'hA5A5_0000 + AW'(i * 16));
        end
        reg_read(3'd4, d);
        check("R2 control keeps 12 bits", d, 32'h0000_0FFF);
        reg_read(3'd6, d);
        check("R2 index 6 reads 0", d, '0);
        reg_write(3'd4, '0);
    endtask

    task automatic t_fetch();
        reg_write(3'd0, 32'h0000_1000);
        reg_write(3'd4, ctl(4'b0001, M_FETCH, M_FETCH, M_FETCH, M_FETCH));
        access("R3 fetch read ignored", K_READ, 32'h0000_1000, 1'b0, 4'b0000);
        access("R3 fetch write ignored", K_WRITE, 32'h0000_1000, 1'b0, 4'b0000);
        access("R3 fetch hit", K_FETCH, 32'h0000_1000, 1'b1, 4'b0001);
        clear_status();
    endtask

    task automatic t_write();
        reg_write(3'd1, 32'h2000_0040);
        reg_write(3'd4, ctl(4'b0010, M_FETCH, M_FETCH, M_WRITE, M_FETCH));
        access("R4 write-mode fetch ignored", K_FETCH, 32'h2000_0040, 1'b0, 4'b0000);
        access("R4 write-mode read ignored", K_READ, 32'h2000_0040, 1'b0, 4'b0000);
        access("R4 write hit", K_WRITE, 32'h2000_0040, 1'b1, 4'b0010);
        clear_status();
    endtask

    task automatic t_rdwr();
        reg_write(3'd2, 32'h3333_0008);
        reg_write(3'd4, ctl(4'b0100, M_FETCH, M_RDWR, M_FETCH, M_FETCH));
        access("R5 rdwr fetch ignored", K_FETCH, 32'h3333_0008, 1'b0, 4'b0000);
        access("R5 rdwr read hit", K_READ, 32'h3333_0008, 1'b1, 4'b0100);
        clear_status();
        access("R5 rdwr write hit", K_WRITE, 32'h3333_0008, 1'b1, 4'b0100);
        clear_status();
    endtask

    task automatic t_rsvd();
        reg_write(3'd3, 32'h4444_0000);
        reg_write(3'd4, ctl(4'b1000, M_RSVD, M_FETCH, M_FETCH, M_FETCH));
        access("R6 reserved fetch", K_FETCH, 32'h4444_0000, 1'b0, 4'b0000);
        access("R6 reserved read", K_READ, 32'h4444_0000, 1'b0, 4'b0000);
        access("R6 reserved write", K_WRITE, 32'h4444_0000, 1'b0, 4'b0000);
        reg_write(3'd4, ctl(4'b1000, M_RDWR, M_FETCH, M_FETCH, M_FETCH));
        access("R6 kind 11 never matches", K_NONE, 32'h4444_0000, 1'b0, 4'b0000);
    endtask

    task automatic t_disabled();
        reg_write(3'd0, 32'h5555_0000);
        reg_write(3'd4, ctl(4'b0000, M_RDWR, M_RDWR, M_RDWR, M_RDWR));
        access("R7 disabled channel silent", K_WRITE, 32'h5555_0000, 1'b0, 4'b0000);
        reg_write(3'd4, ctl(4'b0001, M_RDWR, M_RDWR, M_RDWR, M_RDWR));
        access("R7 enabled hit", K_WRITE, 32'h5555_0000, 1'b1, 4'b0001);
        reg_write(3'd4, ctl(4'b0000, M_RDWR, M_RDWR, M_RDWR, M_RDWR));
        access("R7 disabled keeps status", K_READ, 32'h5555_0000, 1'b0, 4'b0001);
        clear_status();
    endtask

    task automatic t_valid_low();
        reg_write(3'd0, 32'h6666_0000);
        reg_write(3'd4, ctl(4'b0001, M_FETCH, M_FETCH, M_FETCH, M_RDWR));
        @(negedge clk);
        mon_valid = 1'b0; mon_kind = K_WRITE; mon_addr = 32'h6666_0000;
        @(negedge clk);
        check("R8 no req without valid", AW'(brk_req), '0);
        check("R8 no status without valid", AW'(brk_status), '0);
        mon_kind = K_NONE;
    endtask

    task automatic t_multi();
        reg_write(3'd0, 32'h7777_0010);
        reg_write(3'd2, 32'h7777_0010);
        reg_write(3'd3, 32'h7777_0010);
        reg_write(3'd4, ctl(4'b1101, M_FETCH, M_WRITE, M_FETCH, M_RDWR));
        access("R9 two channels on write", K_WRITE, 32'h7777_0010, 1'b1, 4'b0101);
        clear_status();
        access("R9 one channel on read", K_READ, 32'h7777_0010, 1'b1, 4'b0001);
        clear_status();
        access("R9 one channel on fetch", K_FETCH, 32'h7777_0010, 1'b1, 4'b1000);
        clear_status();
    endtask

    task automatic t_sticky();
        logic [AW-1:0] d;
        reg_write(3'd0, 32'h8000_0000);
        reg_write(3'd1, 32'h8000_0004);
        reg_write(3'd4, ctl(4'b0011, M_FETCH, M_FETCH, M_RDWR, M_RDWR));
        access("R10 first hit", K_READ, 32'h8000_0000, 1'b1, 4'b0001);
        repeat (3) @(negedge clk);
        check("R10 status held while idle", AW'(brk_status), 32'h1);
        reg_write(3'd5, 32'hF);
        check("R10 writing ones keeps bits", AW'(brk_status), 32'h1);
        access("R10 second hit adds bit", K_WRITE, 32'h8000_0004, 1'b1, 4'b0011);
        reg_read(3'd5, d);
        check("R10 status readback", d, 32'h3);
        reg_write(3'd5, 32'hE);
        check("R10 zero clears only that bit", AW'(brk_status), 32'h2);
        // Clear everything while channel 0 hits in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd5; cfg_wdata = '0;
        mon_valid = 1'b1; mon_kind = K_READ; mon_addr = 32'h8000_0000;
        @(negedge clk);
        cfg_we = 1'b0; mon_valid = 1'b0; mon_kind = K_NONE;
        check("R10 hit wins over clear", AW'(brk_status), 32'h1);
        check("R10 req on simultaneous clear", AW'(brk_req), 32'h1);
        clear_status();
        check("R10 cleared", AW'(brk_status), '0);
    endtask

    task automatic t_addr_bits();
        reg_write(3'd0, 32'h1234_5678);
        reg_write(3'd4, ctl(4'b0001, M_FETCH, M_FETCH, M_FETCH, M_FETCH));
        access("R11 low bit differs", K_FETCH, 32'h1234_5679, 1'b0, 4'b0000);
        access("R11 high bit differs", K_FETCH, 32'h9234_5678, 1'b0, 4'b0000);
        access("R11 exact address hits", K_FETCH, 32'h1234_5678, 1'b1, 4'b0001);
        clear_status();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_fetch();
        t_write();
        t_rdwr();
        t_rsvd();
        t_disabled();
        t_valid_low();
        t_multi();
        t_sticky();
        t_addr_bits();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule